// File: doc/BRIEF.md
# Serial Converter Front-End with Strobe-Driven Power States

This block models the digital side of a two-channel 10-bit sampling converter that a host reads over a three-wire serial link. A start strobe, a serial clock and an active-low sleep pin drive it. All of them are sampled on a fast system clock. A falling strobe captures one of two supplied sample codes. The block then shifts a 16-bit frame out on a data line that it can release to high impedance. The output is modelled as a data bit plus an enable. The block also reports whether its track/hold is acquiring or holding.

The same strobe also selects the power state. The block counts rising serial-clock edges after each strobe fall. Where the next strobe rise falls relative to that count decides the next power state: unchanged, one step deeper (normal to partial, partial to full), or back to normal. The sleep pin overrides the strobe. While it is low the block is in full power-down, and releasing it always gives normal operation.

Top module: `adcif_serial_pd`

## Requirements
- R1: After reset, the power state `pwr_o` is full power-down. The encoding is 0 normal, 1 partial, 2 full. The output enable is low and `hold_o` is low.
- R2: The first strobe rise after reset moves the block to normal, whatever the edge count.
- R3: A strobe fall captures the code of channel 1 when `ch_sel_i` is high and of channel 0 when it is low. It also captures `twos_i`. In the following cycle the output is enabled and driven low, and `hold_o` is high. Later changes to the select, format and code pins do not alter the frame.
- R4: After the k-th rising serial-clock edge of a frame, the data bit is 0 for k = 1..5 and for k = 16. For k = 6..15 it is code bit 15-k, so the MSB comes first.
- R5: With `twos_i` high at the fall, the code's MSB is inverted. This turns offset binary into two's complement.
- R6: `hold_o` drops on the 13th falling serial-clock edge after the strobe fell, or earlier if the strobe rises first.
- R7: Every strobe rise disables the output in the following cycle.
- R8: A rise after 4 to 12 rising edges moves normal to partial, and partial or full to full.
- R9: A rise after fewer than 4 rising edges leaves the power state unchanged.
- R10: A rise after 13 or more rising edges returns any state to normal.
- R11: If the strobe is still low at the 16th rising edge, the next rising edge disables the output.
- R12: While `sleep_n_i` is low, the state is full, the output is disabled, `hold_o` is low and strobe edges are ignored. Its release gives normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion start strobe |
| sck_i | input | 1 | Serial clock from the host |
| sleep_n_i | input | 1 | Active-low forced shutdown |
| ch_sel_i | input | 1 | Channel select, high picks channel 1 |
| twos_i | input | 1 | Output format, high for two's complement |
| code0_i | input | 10 | Sample code of channel 0 |
| code1_i | input | 10 | Sample code of channel 1 |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Serial data output enable, low means high impedance |
| pwr_o | output | 2 | Power state: 0 normal, 1 partial, 2 full |
| hold_o | output | 1 | High while the track/hold holds |

## Verification
The properties assume that every pin is synchronous to `clk` and that the strobe and the serial clock never change in the same cycle. The sleep pin is assumed high while reset is held. The bench holds to these assumptions: it changes exactly one control pin at each falling system-clock edge and keeps the sleep pin high through reset. Every serial-clock level lasts one full system-clock period, so each edge is seen exactly once.

// File: rtl/adcif_pkg.sv
package adcif_pkg;
   typedef enum logic [1:0] {
      PWR_NORMAL  = 2'd0,
      PWR_PARTIAL = 2'd1,
      PWR_FULL    = 2'd2
   } pwr_e;
endpackage

// File: rtl/adcif_edge.sv
module adcif_edge #(
   parameter int           W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_i,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= pin_i;
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign rise_o[i] =  pin_i[i] & ~prev_q[i];
      assign fall_o[i] = ~pin_i[i] &  prev_q[i];
   end
endmodule

// File: rtl/adcif_satcnt.sv
module adcif_satcnt #(
   parameter int CNT_W = 5,
   parameter int LIMIT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

   if (LIMIT >= (1 << CNT_W)) begin : g_bad_limit
      $error("adcif_satcnt: LIMIT does not fit in CNT_W");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (clr_i)               cnt_q <= '0;
      else if (inc_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/adcif_shift_out.sv
module adcif_shift_out #(
   parameter int CODE_W     = 10,
   parameter int LEAD_ZEROS = 5,
   parameter int FRAME_LEN  = 16,
   parameter int CNT_W      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort_i,
   input  logic              load_i,
   input  logic [CODE_W-1:0] word_i,
   input  logic              step_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic              sdo_o,
   output logic              sdo_oe_o
);
   localparam logic [CNT_W-1:0] DATA_LO = CNT_W'(LEAD_ZEROS);
   localparam logic [CNT_W-1:0] DATA_HI = CNT_W'(LEAD_ZEROS + CODE_W);
   localparam logic [CNT_W-1:0] LAST    = CNT_W'(FRAME_LEN);

   logic [CODE_W-1:0] sh_q;
   logic              sdo_q, oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         sdo_q <= 1'b0;
         oe_q  <= 1'b0;
      end else if (abort_i) begin
         sdo_q <= 1'b0;
         oe_q  <= 1'b0;
      end else if (load_i) begin
         sh_q  <= word_i;
         sdo_q <= 1'b0;
         oe_q  <= 1'b1;
      end else if (step_i) begin
         if (cnt_i == LAST) begin
            sdo_q <= 1'b0;
            oe_q  <= 1'b0;
         end else if (cnt_i >= DATA_LO && cnt_i < DATA_HI) begin
            sdo_q <= sh_q[CODE_W-1];
            sh_q  <= {sh_q[CODE_W-2:0], 1'b0};
         end else begin
            sdo_q <= 1'b0;
         end
      end
   end

   assign sdo_o    = sdo_q;
   assign sdo_oe_o = oe_q;
endmodule

// File: rtl/adcif_serial_pd.sv
module adcif_serial_pd
   import adcif_pkg::*;
#(
   parameter int CODE_W      = 10,
   parameter int LEAD_ZEROS  = 5,
   parameter int FRAME_LEN   = 16,
   parameter int PD_MIN_EDGE = 4,
   parameter int WAKE_EDGE   = 13,
   parameter int HOLD_EDGE   = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              sck_i,
   input  logic              sleep_n_i,
   input  logic              ch_sel_i,
   input  logic              twos_i,
   input  logic [CODE_W-1:0] code0_i,
   input  logic [CODE_W-1:0] code1_i,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   output logic [1:0]        pwr_o,
   output logic              hold_o
);
   localparam int               CNT_W   = $clog2(FRAME_LEN + 1);
   localparam logic [CNT_W-1:0] PD_MIN  = CNT_W'(PD_MIN_EDGE);
   localparam logic [CNT_W-1:0] WAKE    = CNT_W'(WAKE_EDGE);
   localparam logic [CNT_W-1:0] HOLD_M1 = CNT_W'(HOLD_EDGE - 1);

   if (FRAME_LEN <= LEAD_ZEROS + CODE_W) begin : g_bad_frame
      $error("adcif_serial_pd: frame too short for lead zeros and code");
   end
   if (PD_MIN_EDGE >= WAKE_EDGE || WAKE_EDGE > FRAME_LEN) begin : g_bad_window
      $error("adcif_serial_pd: power-down window out of order");
   end
   if (HOLD_EDGE < 1 || HOLD_EDGE > FRAME_LEN) begin : g_bad_hold
      $error("adcif_serial_pd: hold release edge out of frame");
   end

   // pin order: [2] sleep_n, [1] sck, [0] start
   logic [2:0] rise, fall;
   adcif_edge #(.W(3), .RST_VAL(3'b100)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin_i({sleep_n_i, sck_i, start_i}),
      .rise_o(rise), .fall_o(fall)
   );
   logic st_rise, st_fall, sck_rise, sck_fall, wake;
   assign st_rise  = rise[0];
   assign st_fall  = fall[0];
   assign sck_rise = rise[1];
   assign sck_fall = fall[1];
   assign wake     = rise[2];

   logic live, load, abort;
   assign live  = sleep_n_i & ~wake;
   assign load  = live & st_fall;
   assign abort = ~live | st_rise;

   logic [CNT_W-1:0] rcnt, fcnt;
   adcif_satcnt #(.CNT_W(CNT_W), .LIMIT(FRAME_LEN)) u_rcnt (
      .clk(clk), .rst_n(rst_n), .clr_i(load), .inc_i(sck_rise), .cnt_o(rcnt)
   );
   adcif_satcnt #(.CNT_W(CNT_W), .LIMIT(FRAME_LEN)) u_fcnt (
      .clk(clk), .rst_n(rst_n), .clr_i(load), .inc_i(sck_fall), .cnt_o(fcnt)
   );

   logic [CODE_W-1:0] word;
   always_comb begin
      word = ch_sel_i ? code1_i : code0_i;
      if (twos_i) word[CODE_W-1] = ~word[CODE_W-1];
   end

   adcif_shift_out #(
      .CODE_W(CODE_W), .LEAD_ZEROS(LEAD_ZEROS), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)
   ) u_out (
      .clk(clk), .rst_n(rst_n), .abort_i(abort), .load_i(load), .word_i(word),
      .step_i(sck_rise), .cnt_i(rcnt), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
   );

   pwr_e pwr_q;
   logic boot_q, frame_q, hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_q   <= PWR_FULL;
         boot_q  <= 1'b1;
         frame_q <= 1'b0;
         hold_q  <= 1'b0;
      end else if (!sleep_n_i) begin
         pwr_q   <= PWR_FULL;
         boot_q  <= 1'b0;
         frame_q <= 1'b0;
         hold_q  <= 1'b0;
      end else if (wake) begin
         pwr_q   <= PWR_NORMAL;
         frame_q <= 1'b0;
         hold_q  <= 1'b0;
      end else if (st_fall) begin
         frame_q <= 1'b1;
         hold_q  <= 1'b1;
      end else if (st_rise) begin
         frame_q <= 1'b0;
         hold_q  <= 1'b0;
         if (boot_q) begin
            pwr_q  <= PWR_NORMAL;
            boot_q <= 1'b0;
         end else if (frame_q) begin
            if (rcnt >= WAKE)
               pwr_q <= PWR_NORMAL;
            else if (rcnt >= PD_MIN)
               pwr_q <= (pwr_q == PWR_NORMAL) ? PWR_PARTIAL : PWR_FULL;
         end
      end else if (sck_fall && frame_q && fcnt == HOLD_M1) begin
         hold_q <= 1'b0;
      end
   end

   assign pwr_o  = pwr_q;
   assign hold_o = hold_q;
endmodule

// File: rtl/adcif_serial_pd_chk.sv
module adcif_serial_pd_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       sck_i,
   input logic       sleep_n_i,
   input logic       sdo_o,
   input logic       sdo_oe_o,
   input logic [1:0] pwr_o,
   input logic       hold_o
);
   assert_reset_state_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (pwr_o == 2'd2 && !sdo_oe_o && !hold_o));

   assert_fall_drives_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(start_i) && sleep_n_i && $past(sleep_n_i)) |=> (sdo_oe_o && !sdo_o && hold_o));

   assert_quiet_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(start_i) && $stable(sck_i) && $stable(sleep_n_i))
      |=> ($stable(pwr_o) && $stable(sdo_o) && $stable(sdo_oe_o) && $stable(hold_o)));

   assert_rise_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_i) |=> !sdo_oe_o);

   assert_sleep_forces_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_n_i |=> (pwr_o == 2'd2 && !sdo_oe_o && !hold_o));

   assert_wake_normal_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_n_i) |=> (pwr_o == 2'd0));
endmodule

bind adcif_serial_pd adcif_serial_pd_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .sck_i(sck_i), .sleep_n_i(sleep_n_i),
   .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .pwr_o(pwr_o), .hold_o(hold_o)
);

// File: tb/adcif_serial_pd_test.sv
module adcif_serial_pd_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0, sck = 1'b0, sleep_n = 1'b1, ch_sel = 1'b0, twos = 1'b0;
   logic [9:0] code0 = '0, code1 = '0;
   logic       sdo, sdo_oe, hold;
   logic [1:0] pwr;
   int         checks = 0, fails = 0;

   always #4 clk = ~clk;

   adcif_serial_pd uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .sck_i(sck), .sleep_n_i(sleep_n),
      .ch_sel_i(ch_sel), .twos_i(twos), .code0_i(code0), .code1_i(code1),
      .sdo_o(sdo), .sdo_oe_o(sdo_oe), .pwr_o(pwr), .hold_o(hold)
   );

   typedef struct packed {
      logic [4:0] n;
      logic       ch;
      logic       tw;
      logic [9:0] c0;
      logic [9:0] c1;
      logic [1:0] pw;
   } vec_t;

   localparam vec_t VEC [14] = '{
      '{5'd16, 1'b0, 1'b0, 10'h2A5, 10'h1C3, 2'd0},
      '{5'd16, 1'b1, 1'b0, 10'h2A5, 10'h1C3, 2'd0},
      '{5'd16, 1'b1, 1'b1, 10'h0F0, 10'h155, 2'd0},
      '{5'd14, 1'b0, 1'b1, 10'h3FF, 10'h001, 2'd0},
      '{5'd2,  1'b0, 1'b0, 10'h111, 10'h222, 2'd0},
      '{5'd8,  1'b1, 1'b0, 10'h333, 10'h0AA, 2'd1},
      '{5'd3,  1'b0, 1'b0, 10'h123, 10'h321, 2'd1},
      '{5'd4,  1'b0, 1'b1, 10'h0FF, 10'h300, 2'd2},
      '{5'd12, 1'b1, 1'b1, 10'h050, 10'h3C7, 2'd2},
      '{5'd13, 1'b0, 1'b0, 10'h2DB, 10'h124, 2'd0},
      '{5'd12, 1'b1, 1'b0, 10'h18E, 10'h271, 2'd1},
      '{5'd16, 1'b1, 1'b0, 10'h000, 10'h2C9, 2'd0},
      '{5'd16, 1'b0, 1'b1, 10'h000, 10'h3FF, 2'd0},
      '{5'd15, 1'b1, 1'b1, 10'h200, 10'h1FF, 2'd0}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_frame(input vec_t v);
      logic [9:0] w;
      logic       b;
      w = v.ch ? v.c1 : v.c0;
      if (v.tw) w[9] = ~w[9];
      @(negedge clk);
      code0 = v.c0; code1 = v.c1; ch_sel = v.ch; twos = v.tw; start = 1'b0;
      @(negedge clk);
      chk("R3 fall", {13'd0, sdo_oe, sdo, hold}, 16'h5);
      ch_sel = ~v.ch; twos = ~v.tw; code0 = ~v.c0; code1 = ~v.c1;
      for (int k = 1; k <= int'(v.n); k++) begin
         sck = 1'b1;
         @(negedge clk);
         b = (k >= 6 && k <= 15) ? w[15-k] : 1'b0;
         chk(v.tw ? "R5 bit" : "R4 bit", {14'd0, sdo_oe, sdo}, {14'd0, 1'b1, b});
         sck = 1'b0;
         @(negedge clk);
         chk("R6 hold", {15'd0, hold}, {15'd0, (k < 13)});
      end
      start = 1'b1;
      @(negedge clk);
      chk("R7 release", {15'd0, sdo_oe}, 16'd0);
      chk("R6 hold on rise", {15'd0, hold}, 16'd0);
      if (v.n < 4)       chk("R9 state", {14'd0, pwr}, {14'd0, v.pw});
      else if (v.n < 13) chk("R8 state", {14'd0, pwr}, {14'd0, v.pw});
      else               chk("R10 state", {14'd0, pwr}, {14'd0, v.pw});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset", {13'd0, pwr, sdo_oe, hold}, 16'h8);
      start = 1'b1;
      @(negedge clk);
      chk("R2 boot wake", {14'd0, pwr}, 16'd0);

      foreach (VEC[i]) run_frame(VEC[i]);

      // R11: strobe held low past the frame end
      @(negedge clk); start = 1'b0;
      for (int k = 1; k <= 16; k++) begin
         @(negedge clk); sck = 1'b1;
         @(negedge clk); sck = 1'b0;
      end
      @(negedge clk);
      chk("R11 still driven", {15'd0, sdo_oe}, 16'd1);
      sck = 1'b1;
      @(negedge clk);
      chk("R11 released", {15'd0, sdo_oe}, 16'd0);
      sck = 1'b0;
      @(negedge clk); start = 1'b1;
      @(negedge clk);
      chk("R10 after long frame", {14'd0, pwr}, 16'd0);

      // R12: sleep pin overrides strobe
      sleep_n = 1'b0;
      @(negedge clk);
      chk("R12 sleep", {13'd0, pwr, sdo_oe, hold}, 16'h8);
      start = 1'b0;
      @(negedge clk);
      chk("R12 fall ignored", {13'd0, pwr, sdo_oe, hold}, 16'h8);
      start = 1'b1;
      @(negedge clk);
      chk("R12 rise ignored", {14'd0, pwr}, 16'd2);
      sleep_n = 1'b1;
      @(negedge clk);
      chk("R12 wake", {14'd0, pwr}, 16'd0);

      // R12: sleep mid-frame from partial power-down
      run_frame('{5'd6, 1'b0, 1'b0, 10'h0C3, 10'h13C, 2'd1});
      @(negedge clk); start = 1'b0;
      @(negedge clk); sck = 1'b1;
      @(negedge clk); sleep_n = 1'b0;
      @(negedge clk);
      chk("R12 mid-frame", {13'd0, pwr, sdo_oe, hold}, 16'h8);
      sck = 1'b0;
      @(negedge clk); sleep_n = 1'b1;
      @(negedge clk);
      chk("R12 wake from partial", {14'd0, pwr}, 16'd0);
      start = 1'b1;
      @(negedge clk);
      chk("R9 rise with no frame", {14'd0, pwr}, 16'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule